// File: doc/BRIEF.md
# CCD Horizontal Line Timing Generator

This block produces the pixel-rate control signals that clock one line of an interline CCD out through its horizontal shift register. It runs from a tick clock at twice the pixel rate, so one pixel period is two ticks. At the 25 MHz pixel rate this is a 50 MHz tick. Each line lasts a fixed number of pixel periods and is split into readout and horizontal blanking. During readout the two complementary horizontal transfer phases toggle on every tick. The final-stage transfer clock follows the second phase. During blanking the phases are parked.

A reset-gate pulse occupies the first tick of every pixel period. A registered region code tells the downstream sample path what each pixel is: dummy, front optical black, effective, the flagged ignored edge columns of the effective area, rear optical black, or blanking. The region code is cycle-aligned with the phases. A one-tick horizontal sync strobe marks the first tick of each line. A vertical-transfer window opens only inside blanking, kept clear of both blanking edges by a guard band, so that vertical shifts never overlap horizontal shifting.

The enable input is honoured only between lines. Dropping it mid-line lets the current line finish. Raising it while idle starts a line from its first pixel.

Top module: `hline_timer`

## Requirements
- R1: During reset, and while idle (not running), the outputs are h1=1, h2=0, lh=0, rg=0, hsync=0, vwin=0 and region=0 (blanking).
- R2: While enable stays high, lines follow back to back, and hsync rises every 2*LINE_LEN ticks.
- R3: Pixel p of a line (p from 0) carries these region codes: 1 (dummy) for p < DUMMY_W; then 2 (front optical black) for FOB_W pixels; then 3 (effective) for EFF_W pixels; then 4 (rear optical black) for ROB_W pixels; then 0 (blanking) up to LINE_LEN-1.
- R4: Within the effective run, the first IGN_W and the last IGN_W pixels carry code 5 (ignored) instead of 3.
- R5: On a readout pixel (code not 0), h1 is 1 on the first tick and 0 on the second, and h2 is always the complement of h1. On a blanking pixel, h1=1 and h2=0 on both ticks.
- R6: lh equals h2 on every tick.
- R7: While running, rg is 1 on the first tick of every pixel period (blanking included) and 0 on the second.
- R8: vwin is 1 exactly on both ticks of blanking pixels p with ROB_END+GUARD <= p <= LINE_LEN-1-GUARD, where ROB_END=DUMMY_W+FOB_W+EFF_W+ROB_W. It is 0 elsewhere.
- R9: enable is sampled only when idle or at the last tick of a line. If it falls or pulses within a line, that line completes unchanged. If enable is first seen high at a clock edge while idle, pixel 0 appears on the outputs one edge later.
- R10: hsync is 1 for exactly the first tick of pixel 0 of each line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, two ticks per pixel period |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Run request, honoured at line boundaries |
| h1 | output | 1 | First horizontal transfer phase |
| h2 | output | 1 | Second horizontal transfer phase, complement of h1 |
| lh | output | 1 | Final-stage transfer clock, aligned with h2 |
| rg | output | 1 | Reset-gate pulse, first tick of each pixel |
| hsync | output | 1 | One-tick line-start strobe |
| vwin | output | 1 | Window in which vertical transfer may occur |
| region | output | 3 | Region code of the current pixel |

## Verification
The bench builds the block with a 30-pixel line: 3 dummy, 2 front optical black, 12 effective with 2 ignored at each edge, 3 rear optical black, 10 blanking, and a guard of 2. With this line every tick of every line can be compared against values computed from the pixel index. So every region boundary, both ignored edges, the guard-band edges of the vertical window and the line wrap are each hit several times. The short line also lets the bench glitch enable inside one line, drop it inside another, and watch the clean stop and the idle state that follows in a few hundred ticks.

// File: rtl/hline_pkg.sv
// Shared types for the horizontal line timing generator.
// Assumes a 3-bit region code read by the downstream sample path.
package hline_pkg;

    typedef enum logic [2:0] {
        RGN_BLANK = 3'd0,
        RGN_DUMMY = 3'd1,
        RGN_FOB   = 3'd2,
        RGN_EFF   = 3'd3,
        RGN_ROB   = 3'd4,
        RGN_IGN   = 3'd5
    } region_t;

endpackage

// File: rtl/hline_counter.sv
// Pixel position counter for one CCD line.
// Keeps a half-period bit (two ticks per pixel) and a pixel index that wraps
// at LINE_LEN-1. The run flag samples enable only while idle or on the last
// tick of a line, so a line is never cut short.
// Assumes LINE_LEN >= 2.
module hline_counter #(
    parameter int LINE_LEN = 3621,
    localparam int PW = $clog2(LINE_LEN)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    output logic [PW-1:0] pix,
    output logic          half,
    output logic          running,
    output logic          line_start
);

    localparam logic [PW-1:0] LAST_PIX = PW'(LINE_LEN - 1);

    // Advance half-period and pixel index; resample enable at line boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            running <= 1'b0;
            pix     <= '0;
            half    <= 1'b0;
        end else if (!running) begin
            running <= enable;
            pix     <= '0;
            half    <= 1'b0;
        end else begin
            half <= ~half;
            if (half) begin
                if (pix == LAST_PIX) begin
                    pix     <= '0;
                    running <= enable;
                end else begin
                    pix <= pix + 1'b1;
                end
            end
        end
    end

    // First tick of pixel 0 of a running line.
    always_comb begin
        line_start = running && (pix == '0) && !half;
    end

endmodule

// File: rtl/hline_decode.sv
// Maps a pixel index to its region code, a readout flag and the
// vertical-window qualifier. Purely combinational.
// Assumes DUMMY_W+FOB_W+EFF_W+ROB_W+2*GUARD < LINE_LEN and 2*IGN_W <= EFF_W.
module hline_decode
    import hline_pkg::*;
#(
    parameter int LINE_LEN = 3621,
    parameter int DUMMY_W  = 31,
    parameter int FOB_W    = 20,
    parameter int EFF_W    = 3040,
    parameter int ROB_W    = 50,
    parameter int IGN_W    = 4,
    parameter int GUARD    = 8,
    localparam int PW = $clog2(LINE_LEN)
) (
    input  logic [PW-1:0] pix,
    input  logic          running,
    output region_t       region,
    output logic          readout,
    output logic          vwin_pix
);

    localparam int FOB_START = DUMMY_W;
    localparam int EFF_START = FOB_START + FOB_W;
    localparam int ROB_START = EFF_START + EFF_W;
    localparam int ROB_END   = ROB_START + ROB_W;

    localparam logic [PW-1:0] P_FOB   = PW'(FOB_START);
    localparam logic [PW-1:0] P_EFF   = PW'(EFF_START);
    localparam logic [PW-1:0] P_ROB   = PW'(ROB_START);
    localparam logic [PW-1:0] P_BLK   = PW'(ROB_END);
    localparam logic [PW-1:0] P_VOPEN = PW'(ROB_END + GUARD);
    localparam logic [PW-1:0] P_VSHUT = PW'(LINE_LEN - 1 - GUARD);

    logic [PW-1:0] eff_idx;
    logic          eff_edge;

    // Offset of the pixel within the effective run.
    always_comb begin
        eff_idx = pix - P_EFF;
    end

    // Ignored-edge flag; absent when no edge columns are configured.
    generate
        if (IGN_W > 0) begin : g_ign
            localparam logic [PW-1:0] P_IGN_LO = PW'(IGN_W);
            localparam logic [PW-1:0] P_IGN_HI = PW'(EFF_W - IGN_W);
            always_comb begin
                eff_edge = (eff_idx < P_IGN_LO) || (eff_idx >= P_IGN_HI);
            end
        end else begin : g_no_ign
            always_comb begin
                eff_edge = 1'b0;
            end
        end
    endgenerate

    // Region code from the pixel position, blanking when not running.
    always_comb begin
        if (!running)            region = RGN_BLANK;
        else if (pix < P_FOB)    region = RGN_DUMMY;
        else if (pix < P_EFF)    region = RGN_FOB;
        else if (pix < P_ROB)    region = eff_edge ? RGN_IGN : RGN_EFF;
        else if (pix < P_BLK)    region = RGN_ROB;
        else                     region = RGN_BLANK;
    end

    // Readout and vertical-window qualifiers.
    always_comb begin
        readout  = running && (pix < P_BLK);
        vwin_pix = running && (pix >= P_VOPEN) && (pix <= P_VSHUT);
    end

endmodule

// File: rtl/hline_outreg.sv
// Output stage: forms the horizontal phases, final-stage clock and
// reset gate from the half-period bit, and registers them together with
// the region code, sync strobe and vertical window so all leave on the
// same tick.
// Assumes inputs come from the counter and decoder of the same cycle.
module hline_outreg
    import hline_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       running,
    input  logic       half,
    input  logic       readout,
    input  logic       vwin_pix,
    input  logic       line_start,
    input  region_t    region_in,
    output logic       h1,
    output logic       h2,
    output logic       lh,
    output logic       rg,
    output logic       hsync,
    output logic       vwin,
    output logic [2:0] region
);

    logic ph1_next;
    logic ph2_next;

    // Phase values: toggling in readout, parked h1 high in blanking.
    always_comb begin
        ph1_next = readout ? !half : 1'b1;
        ph2_next = readout ? half  : 1'b0;
    end

    // Register every line-timing output on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h1     <= 1'b1;
            h2     <= 1'b0;
            lh     <= 1'b0;
            rg     <= 1'b0;
            hsync  <= 1'b0;
            vwin   <= 1'b0;
            region <= RGN_BLANK;
        end else begin
            h1     <= ph1_next;
            h2     <= ph2_next;
            lh     <= ph2_next;
            rg     <= running && !half;
            hsync  <= line_start;
            vwin   <= vwin_pix;
            region <= region_in;
        end
    end

endmodule

// File: rtl/hline_timer.sv
// Top of the CCD horizontal line timing generator. Runs on a tick clock at
// twice the pixel rate and emits per-pixel phases, reset gate, region code,
// line sync and the vertical-transfer window for fixed-layout lines.
// Assumes synchronous active-low reset and enable from the same clock domain.
module hline_timer #(
    parameter int LINE_LEN = 3621,
    parameter int DUMMY_W  = 31,
    parameter int FOB_W    = 20,
    parameter int EFF_W    = 3040,
    parameter int ROB_W    = 50,
    parameter int IGN_W    = 4,
    parameter int GUARD    = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    output logic       h1,
    output logic       h2,
    output logic       lh,
    output logic       rg,
    output logic       hsync,
    output logic       vwin,
    output logic [2:0] region
);

    localparam int PW = $clog2(LINE_LEN);

    logic [PW-1:0]        pix;
    logic                 half;
    logic                 running;
    logic                 line_start;
    hline_pkg::region_t   rgn_cur;
    logic                 readout;
    logic                 vwin_pix;

    hline_counter #(
        .LINE_LEN (LINE_LEN)
    ) u_counter (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .pix        (pix),
        .half       (half),
        .running    (running),
        .line_start (line_start)
    );

    hline_decode #(
        .LINE_LEN (LINE_LEN),
        .DUMMY_W  (DUMMY_W),
        .FOB_W    (FOB_W),
        .EFF_W    (EFF_W),
        .ROB_W    (ROB_W),
        .IGN_W    (IGN_W),
        .GUARD    (GUARD)
    ) u_decode (
        .pix      (pix),
        .running  (running),
        .region   (rgn_cur),
        .readout  (readout),
        .vwin_pix (vwin_pix)
    );

    hline_outreg u_outreg (
        .clk        (clk),
        .rst_n      (rst_n),
        .running    (running),
        .half       (half),
        .readout    (readout),
        .vwin_pix   (vwin_pix),
        .line_start (line_start),
        .region_in  (rgn_cur),
        .h1         (h1),
        .h2         (h2),
        .lh         (lh),
        .rg         (rg),
        .hsync      (hsync),
        .vwin       (vwin),
        .region     (region)
    );

endmodule

// File: rtl/hline_timer_chk.sv
// Property checker for hline_timer, bound to every instance of the top.
// Observes only the top-level outputs.
module hline_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       h1,
    input logic       h2,
    input logic       lh,
    input logic       rg,
    input logic       hsync,
    input logic       vwin,
    input logic [2:0] region
);

    AST_PHASE_COMPL: assert property (@(posedge clk) disable iff (!rst_n)
        h1 != h2); // R5
    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (region != 3'd0 && $past(region) != 3'd0) |-> (h1 != $past(h1))); // R5
    AST_BLANK_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (region == 3'd0) |-> (h1 && !h2)); // R5
    AST_LH_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        lh == h2); // R6
    AST_RG_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rg |=> !rg); // R7
    AST_RG_FIRST_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (rg && region != 3'd0) |-> h1); // R7
    AST_VWIN_BLANK_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        vwin |-> (region == 3'd0)); // R8
    AST_VWIN_STILL: assert property (@(posedge clk) disable iff (!rst_n)
        (vwin && $past(vwin)) |-> ($stable(h1) && $stable(h2))); // R8
    AST_HSYNC_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |=> !hsync); // R10
    AST_HSYNC_FIRST_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        hsync |-> rg); // R10

endmodule

bind hline_timer hline_timer_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .h1     (h1),
    .h2     (h2),
    .lh     (lh),
    .rg     (rg),
    .hsync  (hsync),
    .vwin   (vwin),
    .region (region)
);

// File: tb/hline_timer_bench.sv
// Sweep bench for hline_timer on a small line layout: every tick of
// several lines is compared with values computed from the pixel index.
module hline_timer_bench;

    localparam int L   = 30;
    localparam int D   = 3;
    localparam int F   = 2;
    localparam int E   = 12;
    localparam int R   = 3;
    localparam int IG  = 2;
    localparam int G   = 2;
    localparam int ROB_END = D + F + E + R;
    localparam int TPL = 2 * L;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       h1, h2, lh, rg, hsync, vwin;
    logic [2:0] region;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    hline_timer #(
        .LINE_LEN (L), .DUMMY_W (D), .FOB_W (F), .EFF_W (E),
        .ROB_W (R), .IGN_W (IG), .GUARD (G)
    ) u_hline_timer (
        .clk (clk), .rst_n (rst_n), .enable (enable),
        .h1 (h1), .h2 (h2), .lh (lh), .rg (rg),
        .hsync (hsync), .vwin (vwin), .region (region)
    );

    always #5 clk = ~clk;

    // Record one check and report a mismatch.
    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // Expected region code for pixel p (R3, R4).
    function automatic int exp_region(input int p);
        int e;
        if (p < D) return 1;
        if (p < D + F) return 2;
        if (p < D + F + E) begin
            e = p - (D + F);
            return (e < IG || e >= E - IG) ? 5 : 3;
        end
        if (p < ROB_END) return 4;
        return 0;
    endfunction

    // Compare every output with the expectation for tick k of a line.
    task automatic check_tick(input int k);
        int p, h, rgn, e1;
        p   = k / 2;
        h   = k % 2;
        rgn = exp_region(p);
        e1  = (rgn != 0) ? (h == 0) : 1;
        chk((rgn == 5 || (p >= D + F && p < D + F + E)) ? "R4" : "R3", "region", int'(region), rgn);
        chk("R5", "h1", int'(h1), e1);
        chk("R5", "h2", int'(h2), 1 - e1);
        chk("R6", "lh", int'(lh), 1 - e1);
        chk("R7", "rg", int'(rg), (h == 0) ? 1 : 0);
        chk("R8", "vwin", int'(vwin), (p >= ROB_END + G && p <= L - 1 - G) ? 1 : 0);
        chk((k == 0) ? "R2" : "R10", "hsync", int'(hsync), (k == 0) ? 1 : 0);
    endtask

    // Compare every output with the idle state.
    task automatic check_idle(input string req);
        chk(req, "idle region", int'(region), 0);
        chk(req, "idle h1", int'(h1), 1);
        chk(req, "idle h2", int'(h2), 0);
        chk(req, "idle lh", int'(lh), 0);
        chk(req, "idle rg", int'(rg), 0);
        chk(req, "idle hsync", int'(hsync), 0);
        chk(req, "idle vwin", int'(vwin), 0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d expected below 20000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: outputs during reset.
        repeat (3) @(negedge clk);
        check_idle("R1");
        rst_n = 1'b1;
        // R1: idle after reset with enable low.
        repeat (5) begin
            @(negedge clk);
            check_idle("R1");
        end
        // R9: start from idle; pixel 0 one edge after enable is seen.
        enable = 1'b1;
        @(negedge clk);
        chk("R9", "no start yet hsync", int'(hsync), 0);
        for (int k = 0; k < 3 * TPL; k++) begin
            @(negedge clk);
            check_tick(k % TPL);
            // Line 2: enable glitch inside the line has no effect (R9).
            if (k == TPL + 10) enable = 1'b0;
            if (k == TPL + 30) enable = 1'b1;
            // Line 3: drop enable mid-line; the line must complete (R9).
            if (k == 2 * TPL + 5) enable = 1'b0;
        end
        // R9: after the completed line the block is idle.
        repeat (8) begin
            @(negedge clk);
            check_idle("R9");
        end
        // Restart and run one more full line (R2, R3).
        enable = 1'b1;
        @(negedge clk);
        for (int k = 0; k < TPL; k++) begin
            @(negedge clk);
            check_tick(k);
        end
        enable = 1'b0;
        @(negedge clk);
        check_tick(0);
        @(negedge clk);
        check_tick(1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule